// File: doc/BRIEF.md
# Debug Chain Selector with CRC-Guarded Selection

This block sits between a JTAG TAP controller and a set of debug scan chains. It watches the 4-bit instruction the TAP has loaded and the TAP's Capture-DR, Shift-DR and Update-DR strobes. While the chain-select instruction is loaded, it owns a 12-bit data register. That register carries a 4-bit chain number in its low bits and an 8-bit CRC in its high bits. The CRC is computed serially as the bits arrive. At Update-DR a well-formed word makes the new chain number the active chain.

While the debug instruction is loaded, the block sends TDI and the three DR strobes to the active chain only, and returns that chain's TDO. The chain number persists across instruction changes. A debugger therefore selects a chain once and then issues many debug transactions to it. A corrupt or truncated selection word leaves the active chain as it was and raises a sticky error flag. Chains that have no function, or codes that are not defined, are served by a one-bit bypass register, so the scan path keeps a defined length.

Top module: `dbg_chain_router`

## Requirements
- R1: After a synchronous reset, `active_chain_o` is 0 (a chain with no function) and `crc_error_o` is 0.
- R2: The chain-select instruction is encoded 4'b0011. Its data word is shifted LSB first: word bits [3:0] are the chain number and bits [11:4] are the CRC, with word bit 4 as CRC bit 0. When Update-DR arrives after exactly 12 shifts and the CRC matches, the chain number appears on `active_chain_o` on the clock edge after the Update-DR cycle.
- R3: The CRC register starts at 0 at Capture-DR and is updated only for the 4 chain-number bits, in shift order. Each step computes feedback = crc[7] XOR bit, shifts the register left by one, and XORs 8'h07 into it when feedback is 1 (polynomial x^8+x^2+x+1).
- R4: If the received CRC differs from the computed CRC at Update-DR, the active chain is unchanged and `crc_error_o` becomes 1. The flag stays 1 through later valid selections until reset.
- R5: An Update-DR under chain-select after any shift count other than 12 is treated the same way as a CRC mismatch.
- R6: Capture-DR under chain-select loads the current chain number and its CRC. While chain-select is loaded, `tdo_o` shows the register's bit 0 before each shift edge, so 12 shifts read back that 12-bit word LSB first.
- R7: Under the debug instruction, encoded 4'b1000, Capture-DR, Shift-DR and Update-DR appear only on bit `active_chain_o` of `chain_capture_o`, `chain_shift_o` and `chain_update_o`. `chain_tdi_o` follows `tdi_i`, and `tdo_o` equals `chain_tdo_i[active_chain_o]`.
- R8: Chains 1, 4 and 5 are live, and chain 3 is live when TRACE_EN is 1. For chain 0, chain 2 or any code of 6 or more, the debug instruction produces no chain strobes. `tdo_o` then comes from a one-bit bypass register that loads 0 at Capture-DR and takes `tdi_i` at each shift, so `tdo_o` lags `tdi_i` by one shift.
- R9: The active chain persists when the instruction changes. A DR scan under any other instruction leaves the active chain unchanged and produces no chain strobes.
- R10: Under instructions other than chain-select and debug, `tdo_o` comes from the bypass register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_i | input | 4 | Current instruction from the TAP |
| capture_dr_i | input | 1 | TAP is in Capture-DR |
| shift_dr_i | input | 1 | TAP is in Shift-DR |
| update_dr_i | input | 1 | TAP is in Update-DR |
| tdi_i | input | 1 | Serial data in |
| chain_tdo_i | input | NUM_PORTS | Serial data out of each chain, indexed by chain code |
| tdo_o | output | 1 | Serial data out toward the TAP |
| chain_tdi_o | output | 1 | Serial data sent to the chains |
| chain_capture_o | output | NUM_PORTS | Per-chain Capture-DR strobe |
| chain_shift_o | output | NUM_PORTS | Per-chain Shift-DR strobe |
| chain_update_o | output | NUM_PORTS | Per-chain Update-DR strobe |
| active_chain_o | output | 4 | Currently selected chain |
| crc_error_o | output | 1 | Sticky flag for a rejected selection word |

## Verification
Selection words with correct CRCs for several chain numbers confirm that the serial CRC and the field positions match the rule. The same words with one CRC bit flipped, and a word cut short by one shift, must be rejected without moving the active chain. Debug scans are run against a live chain, an unused chain and an undefined code. These separate true routing from the bypass path, both by the one-hot strobes and by whether `tdo_o` follows the chain input or lags `tdi_i`. A scan under an unrelated instruction, followed by a return to debug, shows that the selection survives instruction changes.

// File: rtl/dbg_chain_pkg.sv
package dbg_chain_pkg;

    localparam int IR_W    = 4;
    localparam int CHAIN_W = 4;
    localparam int CRC_W   = 8;
    localparam int DR_W    = CHAIN_W + CRC_W;

    localparam logic [CRC_W-1:0] CRC_POLY     = 8'h07;
    localparam logic [IR_W-1:0]  IR_CHAIN_SEL = 4'b0011;
    localparam logic [IR_W-1:0]  IR_DEBUG     = 4'b1000;

    typedef enum logic [CHAIN_W-1:0] {
        CH_IDLE  = 4'd0,
        CH_SPR   = 4'd1,
        CH_SPARE = 4'd2,
        CH_TRACE = 4'd3,
        CH_CTRL  = 4'd4,
        CH_BUS   = 4'd5
    } chain_code_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
        logic tdi;
    } dr_ctl_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] crc,
                                                  input logic bit_in);
        logic fb;
        logic [CRC_W-1:0] nxt;
        fb  = crc[CRC_W-1] ^ bit_in;
        nxt = {crc[CRC_W-2:0], 1'b0};
        if (fb) nxt = nxt ^ CRC_POLY;
        return nxt;
    endfunction

    function automatic logic [CRC_W-1:0] crc_of(input logic [CHAIN_W-1:0] code);
        logic [CRC_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < CHAIN_W; i++) acc = crc_step(acc, code[i]);
        return acc;
    endfunction

    function automatic logic chain_live(input logic [CHAIN_W-1:0] code,
                                        input bit trace_en);
        case (code)
            CH_SPR, CH_CTRL, CH_BUS: return 1'b1;
            CH_TRACE:                return trace_en;
            default:                 return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dbg_chain_bypass.sv
module dbg_chain_bypass (
    input  logic clk,
    input  logic rst,
    input  logic capture_i,
    input  logic shift_i,
    input  logic tdi_i,
    output logic q_o
);
    logic q;

    always_ff @(posedge clk) begin
        if (rst)            q <= 1'b0;
        else if (capture_i) q <= 1'b0;
        else if (shift_i)   q <= tdi_i;
    end

    assign q_o = q;

    // R8: one shift delays tdi by exactly one stage
    assert_bypass_lag_R8: assert property (@(posedge clk) disable iff (rst)
        (shift_i && !capture_i) |=> (q_o == $past(tdi_i)));

endmodule

// File: rtl/dbg_chain_select_reg.sv
module dbg_chain_select_reg
    import dbg_chain_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [IR_W-1:0]    ir_i,
    input  dr_ctl_t            ctl_i,
    output logic               sr_lsb_o,
    output logic [CHAIN_W-1:0] active_o,
    output logic               crc_err_o
);
    localparam int CNT_W = $clog2(DR_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DR_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(DR_W + 1);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(CHAIN_W);

    logic                sel;
    logic [DR_W-1:0]     sr_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CRC_W-1:0]    crc_q;
    logic [CHAIN_W-1:0]  active_q;
    logic                err_q;
    logic                word_ok;

    assign sel     = (ir_i == IR_CHAIN_SEL);
    assign word_ok = (cnt_q == CNT_FULL) && (sr_q[DR_W-1:CHAIN_W] == crc_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q     <= '0;
            cnt_q    <= '0;
            crc_q    <= '0;
            active_q <= CH_IDLE;
            err_q    <= 1'b0;
        end else begin
            if (sel && ctl_i.capture) begin
                sr_q  <= {crc_of(active_q), active_q};
                cnt_q <= '0;
                crc_q <= '0;
            end else if (sel && ctl_i.shift) begin
                sr_q <= {ctl_i.tdi, sr_q[DR_W-1:1]};
                if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
                if (cnt_q < CNT_DATA) crc_q <= crc_step(crc_q, ctl_i.tdi);
            end
            if (sel && ctl_i.update) begin
                if (word_ok) active_q <= sr_q[CHAIN_W-1:0];
                else         err_q    <= 1'b1;
            end
        end
    end

    assign sr_lsb_o  = sr_q[0];
    assign active_o  = active_q;
    assign crc_err_o = err_q;

    // R4: the active chain moves only after an Update-DR under chain-select
    assert_chain_moves_on_update_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_q) |-> $past(sel && ctl_i.update));

    // R4: the error flag is sticky
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !$fell(err_q));

    // R5: the shift counter saturates one above a full word
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_OVER);

endmodule

// File: rtl/dbg_chain_route.sv
module dbg_chain_route
    import dbg_chain_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter bit TRACE_EN  = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IR_W-1:0]      ir_i,
    input  dr_ctl_t              ctl_i,
    input  logic [CHAIN_W-1:0]   active_i,
    input  logic [NUM_PORTS-1:0] chain_tdo_i,
    input  logic                 sel_tdo_i,
    input  logic                 byp_tdo_i,
    output logic                 tdo_o,
    output logic                 chain_tdi_o,
    output logic [NUM_PORTS-1:0] chain_capture_o,
    output logic [NUM_PORTS-1:0] chain_shift_o,
    output logic [NUM_PORTS-1:0] chain_update_o
);
    logic                 dbg;
    logic [NUM_PORTS-1:0] hit;
    logic                 any_hit;
    logic                 chain_tdo;

    assign dbg = (ir_i == IR_DEBUG);

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        localparam logic [CHAIN_W-1:0] CODE = CHAIN_W'(i);
        assign hit[i]             = dbg && (active_i == CODE) && chain_live(CODE, TRACE_EN);
        assign chain_capture_o[i] = hit[i] & ctl_i.capture;
        assign chain_shift_o[i]   = hit[i] & ctl_i.shift;
        assign chain_update_o[i]  = hit[i] & ctl_i.update;
    end

    assign any_hit     = |hit;
    assign chain_tdo   = |(hit & chain_tdo_i);
    assign chain_tdi_o = ctl_i.tdi;

    always_comb begin
        if (ir_i == IR_CHAIN_SEL) tdo_o = sel_tdo_i;
        else if (any_hit)         tdo_o = chain_tdo;
        else                      tdo_o = byp_tdo_i;
    end

    // R7: at most one chain is ever shifted
    assert_one_chain_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chain_shift_o));

    // R9: no chain strobes outside the debug instruction
    assert_quiet_outside_debug_R9: assert property (@(posedge clk) disable iff (rst)
        !dbg |-> (chain_capture_o == '0 && chain_shift_o == '0 && chain_update_o == '0));

endmodule

// File: rtl/dbg_chain_router.sv
module dbg_chain_router
    import dbg_chain_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter bit TRACE_EN  = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [3:0]           ir_i,
    input  logic                 capture_dr_i,
    input  logic                 shift_dr_i,
    input  logic                 update_dr_i,
    input  logic                 tdi_i,
    input  logic [NUM_PORTS-1:0] chain_tdo_i,
    output logic                 tdo_o,
    output logic                 chain_tdi_o,
    output logic [NUM_PORTS-1:0] chain_capture_o,
    output logic [NUM_PORTS-1:0] chain_shift_o,
    output logic [NUM_PORTS-1:0] chain_update_o,
    output logic [3:0]           active_chain_o,
    output logic                 crc_error_o
);
    dr_ctl_t            ctl;
    logic               sel_tdo;
    logic               byp_tdo;
    logic [CHAIN_W-1:0] active;

    assign ctl = '{capture: capture_dr_i, shift: shift_dr_i,
                   update: update_dr_i, tdi: tdi_i};

    dbg_chain_select_reg u_select (
        .clk       (clk),
        .rst       (rst),
        .ir_i      (ir_i),
        .ctl_i     (ctl),
        .sr_lsb_o  (sel_tdo),
        .active_o  (active),
        .crc_err_o (crc_error_o)
    );

    dbg_chain_bypass u_bypass (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture_dr_i),
        .shift_i   (shift_dr_i),
        .tdi_i     (tdi_i),
        .q_o       (byp_tdo)
    );

    dbg_chain_route #(
        .NUM_PORTS (NUM_PORTS),
        .TRACE_EN  (TRACE_EN)
    ) u_route (
        .clk             (clk),
        .rst             (rst),
        .ir_i            (ir_i),
        .ctl_i           (ctl),
        .active_i        (active),
        .chain_tdo_i     (chain_tdo_i),
        .sel_tdo_i       (sel_tdo),
        .byp_tdo_i       (byp_tdo),
        .tdo_o           (tdo_o),
        .chain_tdi_o     (chain_tdi_o),
        .chain_capture_o (chain_capture_o),
        .chain_shift_o   (chain_shift_o),
        .chain_update_o  (chain_update_o)
    );

    assign active_chain_o = active;

endmodule

// File: tb/dbg_chain_router_tb.sv
`timescale 1ns/1ps
module dbg_chain_router_tb_top;

    localparam int NP = 6;
    localparam logic [3:0] SEL = 4'b0011;
    localparam logic [3:0] DBG = 4'b1000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    ir = 4'b0000;
    logic          cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
    logic [NP-1:0] ctdo = 6'b010110;
    logic          tdo, ctdi, err;
    logic [NP-1:0] ccap, csh, cupd;
    logic [3:0]    act;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    dbg_chain_router dut_i (
        .clk(clk), .rst(rst), .ir_i(ir), .capture_dr_i(cap), .shift_dr_i(sh),
        .update_dr_i(upd), .tdi_i(tdi), .chain_tdo_i(ctdo), .tdo_o(tdo),
        .chain_tdi_o(ctdi), .chain_capture_o(ccap), .chain_shift_o(csh),
        .chain_update_o(cupd), .active_chain_o(act), .crc_error_o(err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int actual, input int expected);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    function automatic logic [7:0] crc4(input logic [3:0] c);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < 4; i++) begin
            logic fb;
            fb = r[7] ^ c[i];
            r  = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    // one Capture/Shift(n)/Update scan; returns tdo seen before each shift edge
    task automatic scan(input logic [11:0] w, input int n, output logic [11:0] seen);
        seen = '0;
        @(negedge clk) cap = 1'b1;
        @(negedge clk) cap = 1'b0;
        for (int i = 0; i < n; i++) begin
            sh = 1'b1; tdi = w[i];
            #1 seen[i] = tdo;
            @(negedge clk);
        end
        sh = 1'b0; upd = 1'b1;
        @(negedge clk) upd = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; ir = 4'b0000;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(act == 4'd0, "R1", "active after reset", act, 0);
        check(err == 1'b0, "R1", "error after reset", err, 0);
    endtask

    task automatic t_select(input logic [3:0] c, input logic [7:0] flip,
                            input int n, input logic [3:0] exp_act,
                            input logic exp_err, input string req);
        logic [11:0] seen;
        ir = SEL;
        scan({crc4(c) ^ flip, c}, n, seen);
        check(act == exp_act, req, "active chain", act, exp_act);
        check(err == exp_err, req, "crc error flag", err, exp_err);
    endtask

    task automatic t_readback(input logic [3:0] c);
        logic [11:0] seen;
        logic [11:0] w;
        w = {crc4(c), c};
        ir = SEL;
        scan(w, 12, seen);
        check(seen == w, "R6", "readback word", seen, w);
        check(act == c, "R6", "chain kept after rewrite", act, c);
    endtask

    // debug scan: live chain checks strobes/tdo routing, otherwise bypass
    task automatic t_debug(input logic [3:0] ir_val, input bit live, input int code,
                           input string req);
        logic [4:0] pat = 5'b10110;
        logic [NP-1:0] onehot;
        onehot = live ? NP'(1) << code : '0;
        ir = ir_val;
        @(negedge clk) cap = 1'b1;
        #1 check(ccap == onehot, req, "capture strobes", ccap, onehot);
        @(negedge clk) cap = 1'b0;
        for (int i = 0; i < 5; i++) begin
            logic exp_tdo;
            sh = 1'b1; tdi = pat[i];
            #1;
            exp_tdo = live ? ctdo[code] : (i == 0 ? 1'b0 : pat[i-1]);
            check(csh == onehot, req, "shift strobes", csh, onehot);
            check(tdo == exp_tdo, req, "tdo", tdo, exp_tdo);
            check(ctdi == pat[i], req, "chain tdi", ctdi, pat[i]);
            @(negedge clk);
        end
        sh = 1'b0; upd = 1'b1;
        #1 check(cupd == onehot, req, "update strobes", cupd, onehot);
        @(negedge clk) upd = 1'b0;
    endtask

    initial begin
        do_reset();                                   // R1
        t_select(4'd1, 8'h00, 12, 4'd1, 1'b0, "R2");  // R2, R3
        t_select(4'd5, 8'h00, 11, 4'd1, 1'b1, "R5");  // short word
        do_reset();                                   // R1: flag cleared
        t_select(4'd5, 8'h00, 13, 4'd0, 1'b1, "R5");  // long word
        do_reset();
        t_select(4'd4, 8'h00, 12, 4'd4, 1'b0, "R3");  // R3 CRC of 0100
        t_readback(4'd4);                             // R6
        t_debug(DBG, 1'b1, 4, "R7");                  // R7 chain 4
        t_select(4'd5, 8'h20, 12, 4'd4, 1'b1, "R4");  // bad CRC
        t_select(4'd5, 8'h00, 12, 4'd5, 1'b1, "R4");  // sticky flag
        t_debug(DBG, 1'b1, 5, "R7");
        t_select(4'd3, 8'h00, 12, 4'd3, 1'b1, "R3");
        t_debug(DBG, 1'b1, 3, "R8");                  // trace live by default
        t_select(4'd2, 8'h00, 12, 4'd2, 1'b1, "R2");
        t_debug(DBG, 1'b0, 2, "R8");                  // unused chain
        t_select(4'd9, 8'h00, 12, 4'd9, 1'b1, "R2");
        t_debug(DBG, 1'b0, 9, "R8");                  // undefined code
        t_select(4'd1, 8'h00, 12, 4'd1, 1'b1, "R2");
        t_debug(4'b0001, 1'b0, 1, "R10");             // other IR: bypass
        check(act == 4'd1, "R9", "chain after other IR scan", act, 1);
        t_debug(DBG, 1'b1, 1, "R9");                  // selection persisted
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule